// File: doc/BRIEF.md
# Descriptor-Fetching Memory Copy Channel

This block is one memory-to-memory copy channel that takes its job from a small descriptor in memory rather than from a set of programmed registers. Software places a four-word descriptor somewhere in memory. It writes the byte address of that descriptor into the channel's pointer register, then sets the run bit in the control/status register.

The channel then reads the descriptor over its memory master port. The descriptor holds a flags word, a source address, a destination address and a byte count. The channel copies the data one word at a time: a read from the source, then a write to the destination. After each word it advances whichever addresses the flags ask it to advance. When the count is used up, the run bit drops. If the descriptor asked for it, a sticky completion flag is set and drives the interrupt line. Software clears that flag by writing one to it.

Both ports carry 32-bit words. The memory port holds each request steady until the memory acknowledges it, so the memory may stall for any number of cycles.

Top module: `cbdma_channel`

## Requirements
- R1: Out of reset the control/status register (offset 0x0) reads 0, `irq` is 0 and `mem_req` is 0.
- R2: The descriptor pointer register (offset 0x4) reads back the last value written to it.
- R3: Writing a word with bit 0 set to offset 0x0 while idle starts the channel. Bit 0 of that register (run) then reads 1 on the next cycle. The first four memory accesses are reads of pointer+0 (flags), pointer+4 (source), pointer+8 (destination) and pointer+12 (byte count), in that order.
- R4: With both address steps enabled, the channel copies ceil(count/4) words in order. Each word is a read of source+4k followed by a write of the data just read to destination+4k, so the destination ends up an exact copy of the source.
- R5: Flags bit 8 enables stepping of the source address and flags bit 4 enables stepping of the destination address. When a step bit is clear, every access on that side uses the unchanged address.
- R6: The run bit clears by itself in the cycle after the last write is acknowledged.
- R7: A transfer that completes with flags bit 0 set makes bit 2 of offset 0x0 read 1 and drives `irq` high. With flags bit 0 clear, bit 2 and `irq` stay 0.
- R8: Writing to offset 0x0 with bit 2 set clears the completion flag and `irq`. A write with bit 2 clear leaves the flag unchanged.
- R9: A write to offset 0x0 with bit 0 set while the channel is busy has no effect: the descriptor is not fetched again and no extra word is copied.
- R10: A byte count of 0 ends the job right after the four descriptor reads, with no data access. The completion flag is still raised if flags bit 0 is set.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R12: A byte count that is not a multiple of 4 rounds up to whole words (a count of 6 copies two words).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data is valid in the same cycle |
| mem_rdata | input | 32 | Memory read data |
| irq | output | 1 | Completion interrupt, equal to the completion flag |

## Verification
The bench builds the channel with its default 32-bit address width and 4-bit register offset. It drives it against a 256-word memory model placed in low addresses. That model stalls acknowledges in a pseudo-random pattern, so the hold-until-acknowledged rule is exercised on fetch, read and write accesses alike. Within that window the bench covers copies with and without address stepping, zero and odd byte counts, and a restart attempt made in the middle of a stalled job.

// File: rtl/cbdma_pkg.sv
// Shared constants and types for the descriptor-fetching copy channel.
// Assumes a 32-bit data path and byte addressing with word-aligned accesses.
package cbdma_pkg;
    localparam int DW         = 32;
    localparam int WORD_BYTES = DW / 8;
    localparam int DESC_WORDS = 4;

    // Register byte offsets; software depends on them.
    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_PTR  = 4'h4;

    // Control/status bit positions.
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_FLAG_BIT = 2;

    // Flags-word bit positions inside the descriptor.
    localparam int FLG_IRQ_BIT  = 0;
    localparam int FLG_DINC_BIT = 4;
    localparam int FLG_SINC_BIT = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } eng_state_t;
endpackage

// File: rtl/cbdma_addr_step.sv
// Address stepper: returns the address advanced by one word when stepping
// is enabled, or the same address otherwise. Assumes word-aligned input.
module cbdma_addr_step #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              inc_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    // Next address for this side of the copy.
    always_comb addr_o = inc_i ? addr_i + STEP_V : addr_i;
endmodule

// File: rtl/cbdma_regs.sv
// Register slave: the control/status register and the descriptor pointer.
// Issues a one-cycle start pulse only when the engine is idle. Holds the
// sticky completion flag, which is cleared by writing one to it.
// Assumes single-cycle writes and combinational reads.
module cbdma_regs
    import cbdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        reg_addr,
    input  logic              reg_we,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic              int_en_i,
    output logic              start_o,
    output logic [ADDR_W-1:0] desc_ptr_o,
    output logic              irq_o
);
    logic [ADDR_W-1:0] ptr_q;
    logic              flag_q;
    logic              ctrl_wr;
    logic              clr_req;

    // Decode writes to the control/status register.
    always_comb begin
        ctrl_wr = reg_we && (reg_addr == OFS_CTRL);
        start_o = ctrl_wr && reg_wdata[CTRL_RUN_BIT] && !busy_i;
        clr_req = ctrl_wr && reg_wdata[CTRL_FLAG_BIT];
    end

    // Descriptor pointer storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                               ptr_q <= '0;
        else if (reg_we && reg_addr == OFS_PTR)   ptr_q <= reg_wdata[ADDR_W-1:0];
    end

    // Completion flag: a set in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                   flag_q <= 1'b0;
        else if (done_i && int_en_i)  flag_q <= 1'b1;
        else if (clr_req)             flag_q <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[CTRL_RUN_BIT]  = busy_i;
                reg_rdata[CTRL_FLAG_BIT] = flag_q;
            end
            OFS_PTR: reg_rdata = DW'(ptr_q);
            default: reg_rdata = '0;
        endcase
    end

    assign desc_ptr_o = ptr_q;
    assign irq_o      = flag_q;

    // R7
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(done_i && int_en_i));

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !done_i) |=> !flag_q);
endmodule

// File: rtl/cbdma_engine.sv
// Transfer engine: fetches the four-word descriptor, then copies words by
// a read followed by a write over the memory master port. Each request is
// held until acknowledged. Pulses done_o on the acknowledge that ends a job.
// Assumes read data is valid in the cycle of the acknowledge.
module cbdma_engine
    import cbdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] desc_ptr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              int_en_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DW-1:0]     mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [DW-1:0]     mem_rdata_i
);
    localparam int IDX_W = $clog2(DESC_WORDS);
    localparam logic [DW-1:0]  WB_V     = DW'(WORD_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);

    eng_state_t               state_q;
    logic [IDX_W-1:0]         idx_q;
    logic [ADDR_W-1:0]        desc_q;
    logic [1:0][ADDR_W-1:0]   ptr_q;    // [0] source, [1] destination
    logic [1:0][ADDR_W-1:0]   ptr_nxt;
    logic [1:0]               inc_q;    // [0] source, [1] destination
    logic                     irq_en_q;
    logic [DW-1:0]            remain_q;
    logic [DW-1:0]            data_q;
    logic                     last_word;

    // One stepper per address side.
    for (genvar g = 0; g < 2; g++) begin : g_step
        cbdma_addr_step #(.ADDR_W(ADDR_W), .STEP(WORD_BYTES)) u_step (
            .addr_i (ptr_q[g]),
            .inc_i  (inc_q[g]),
            .addr_o (ptr_nxt[g])
        );
    end

    // Memory request outputs, selected by the current phase.
    always_comb begin
        mem_req_o   = (state_q != ST_IDLE);
        mem_we_o    = (state_q == ST_WRITE);
        mem_wdata_o = data_q;
        case (state_q)
            ST_FETCH: mem_addr_o = desc_q + ADDR_W'({idx_q, 2'b00});
            ST_READ:  mem_addr_o = ptr_q[0];
            ST_WRITE: mem_addr_o = ptr_q[1];
            default:  mem_addr_o = '0;
        endcase
    end

    // A write acknowledge ends the job when at most one word remains.
    always_comb last_word = (remain_q <= WB_V);

    // End-of-job pulse: zero count after the fetch, or the last write.
    always_comb begin
        done_o = 1'b0;
        if (mem_ack_i) begin
            if (state_q == ST_FETCH && idx_q == IDX_LAST && mem_rdata_i == '0) done_o = 1'b1;
            if (state_q == ST_WRITE && last_word)                              done_o = 1'b1;
        end
    end

    // Phase sequencing and capture of descriptor fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            desc_q   <= '0;
            ptr_q    <= '0;
            inc_q    <= '0;
            irq_en_q <= 1'b0;
            remain_q <= '0;
            data_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    desc_q  <= desc_ptr_i;
                    idx_q   <= '0;
                    state_q <= ST_FETCH;
                end
                ST_FETCH: if (mem_ack_i) begin
                    idx_q <= idx_q + 1'b1;
                    case (idx_q)
                        2'd0: begin
                            irq_en_q <= mem_rdata_i[FLG_IRQ_BIT];
                            inc_q    <= {mem_rdata_i[FLG_DINC_BIT], mem_rdata_i[FLG_SINC_BIT]};
                        end
                        2'd1: ptr_q[0] <= mem_rdata_i[ADDR_W-1:0];
                        2'd2: ptr_q[1] <= mem_rdata_i[ADDR_W-1:0];
                        default: begin
                            remain_q <= mem_rdata_i;
                            state_q  <= (mem_rdata_i == '0) ? ST_IDLE : ST_READ;
                        end
                    endcase
                end
                ST_READ: if (mem_ack_i) begin
                    data_q  <= mem_rdata_i;
                    state_q <= ST_WRITE;
                end
                ST_WRITE: if (mem_ack_i) begin
                    ptr_q    <= ptr_nxt;
                    remain_q <= last_word ? '0 : remain_q - WB_V;
                    state_q  <= last_word ? ST_IDLE : ST_READ;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o   = (state_q != ST_IDLE);
    assign int_en_o = irq_en_q;

    // R9
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R6
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(mem_ack_i));

    // R10
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && mem_ack_i && idx_q == IDX_LAST && mem_rdata_i == '0) |=> !busy_o);
endmodule

// File: rtl/cbdma_channel.sv
// Top of the descriptor-fetching copy channel: joins the register slave
// and the transfer engine. The interrupt output is the completion flag.
// Assumes one clock domain and a memory that acknowledges every request.
module cbdma_channel
    import cbdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        reg_addr,
    input  logic              reg_we,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              irq
);
    logic              busy;
    logic              done;
    logic              int_en;
    logic              start;
    logic [ADDR_W-1:0] desc_ptr;

    cbdma_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy_i     (busy),
        .done_i     (done),
        .int_en_i   (int_en),
        .start_o    (start),
        .desc_ptr_o (desc_ptr),
        .irq_o      (irq)
    );

    cbdma_engine #(.ADDR_W(ADDR_W)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .desc_ptr_i  (desc_ptr),
        .busy_o      (busy),
        .done_o      (done),
        .int_en_o    (int_en),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_ack_i   (mem_ack),
        .mem_rdata_i (mem_rdata)
    );
endmodule

// File: tb/cbdma_channel_test.sv
// Directed bench for the copy channel: one task per scenario, each task
// checking its own results against a stalling memory model.
module cbdma_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    cbdma_channel uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
    );

    // Memory model with pseudo-random acknowledge stalls.
    logic [31:0] mem [0:255];
    logic [7:0]  lfsr = 8'h5a;
    logic        stall_on = 1'b1;
    assign mem_ack   = mem_req && (!stall_on || lfsr[0] || lfsr[3]);
    assign mem_rdata = mem[mem_addr[9:2]];

    logic [31:0] log_addr [0:255];
    logic        log_we   [0:255];
    logic [31:0] log_data [0:255];
    int          log_n = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0, pend_data = '0;
    logic        pend_we = 1'b0;
    int          hold_err = 0;

    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (pend && (!mem_req || mem_addr != pend_addr || mem_we != pend_we
                     || (mem_we && mem_wdata != pend_data)))
            hold_err <= hold_err + 1;
        pend      <= rst_n && mem_req && !mem_ack;
        pend_addr <= mem_addr;
        pend_we   <= mem_we;
        pend_data <= mem_wdata;
        if (rst_n && mem_req && mem_ack) begin
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            if (log_n < 256) begin
                log_addr[log_n] <= mem_addr;
                log_we[log_n]   <= mem_we;
                log_data[log_n] <= mem_we ? mem_wdata : mem[mem_addr[9:2]];
            end
            log_n <= log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            reg_read(4'h0, s);
            if (!s[0]) return;
        end
        check(1'b0, "R6 timeout", s, 32'h0);
    endtask

    task automatic put_desc(input logic [31:0] base, input logic [31:0] flg,
                            input logic [31:0] src, input logic [31:0] dst, input logic [31:0] len);
        mem[base[9:2]]     = flg;
        mem[base[9:2] + 1] = src;
        mem[base[9:2] + 2] = dst;
        mem[base[9:2] + 3] = len;
    endtask

    // Compare the access log with the expected fetch and copy sequence.
    task automatic check_seq(input int b, input logic [31:0] desc, input logic [31:0] src,
                             input logic [31:0] dst, input int nw, input bit si, input bit di,
                             input string req);
        check(log_n - b == 4 + 2 * nw, req, 32'(log_n - b), 32'(4 + 2 * nw));
        for (int k = 0; k < 4; k++)
            check(log_addr[b + k] == desc + 32'(4 * k) && !log_we[b + k], "R3 fetch order",
                  log_addr[b + k], desc + 32'(4 * k));
        for (int k = 0; k < nw; k++) begin
            logic [31:0] sa, da;
            sa = si ? src + 32'(4 * k) : src;
            da = di ? dst + 32'(4 * k) : dst;
            check(log_addr[b + 4 + 2 * k] == sa && !log_we[b + 4 + 2 * k], req,
                  log_addr[b + 4 + 2 * k], sa);
            check(log_addr[b + 5 + 2 * k] == da && log_we[b + 5 + 2 * k], req,
                  log_addr[b + 5 + 2 * k], da);
            check(log_data[b + 5 + 2 * k] == log_data[b + 4 + 2 * k], "R4 data",
                  log_data[b + 5 + 2 * k], log_data[b + 4 + 2 * k]);
        end
    endtask

    task automatic t_reset();
        logic [31:0] s;
        reg_read(4'h0, s);
        check(s == 32'h0, "R1 status", s, 32'h0);
        check(irq == 1'b0, "R1 irq", 32'(irq), 32'h0);
        check(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 32'h0);
    endtask

    task automatic t_ptr();
        logic [31:0] s;
        reg_write(4'h4, 32'h0000_0100);
        reg_read(4'h4, s);
        check(s == 32'h100, "R2 pointer", s, 32'h100);
    endtask

    task automatic t_copy();
        logic [31:0] s;
        int b;
        put_desc(32'h100, 32'h111, 32'h20, 32'h40, 32'd32);
        mem[8] = 32'h1234_5678;
        for (int k = 1; k < 8; k++) mem[8 + k] = ~32'h1234_5678 ^ 32'(k);
        for (int k = 0; k < 8; k++) mem[16 + k] = 32'h0;
        reg_write(4'h4, 32'h100);
        b = log_n;
        reg_write(4'h0, 32'h1);
        #1 check(reg_rdata[0] == 1'b1, "R3 run bit", reg_rdata, 32'h1);
        wait_idle();
        check_seq(b, 32'h100, 32'h20, 32'h40, 8, 1'b1, 1'b1, "R4 sequence");
        for (int k = 0; k < 8; k++)
            check(mem[16 + k] == mem[8 + k], "R4 copy", mem[16 + k], mem[8 + k]);
        reg_read(4'h0, s);
        check(s == 32'h4, "R6 R7 status after copy", s, 32'h4);
        check(irq == 1'b1, "R7 irq", 32'(irq), 32'h1);
        reg_write(4'h0, 32'h0);
        reg_read(4'h0, s);
        check(s == 32'h4, "R8 flag kept on write of 0", s, 32'h4);
        reg_write(4'h0, 32'h4);
        reg_read(4'h0, s);
        check(s == 32'h0 && irq == 1'b0, "R8 flag cleared", s, 32'h0);
    endtask

    task automatic t_fixed();
        logic [31:0] s;
        int b;
        put_desc(32'h200, 32'h0, 32'h80, 32'hC0, 32'd12);
        mem[32] = 32'hA5A5_0001;
        reg_write(4'h4, 32'h200);
        b = log_n;
        reg_write(4'h0, 32'h1);
        wait_idle();
        check_seq(b, 32'h200, 32'h80, 32'hC0, 3, 1'b0, 1'b0, "R5 fixed addresses");
        reg_read(4'h0, s);
        check(s == 32'h0 && irq == 1'b0, "R7 no flag when disabled", s, 32'h0);
    endtask

    task automatic t_busy();
        logic [31:0] s;
        int b;
        put_desc(32'h300, 32'h110, 32'h20, 32'h60, 32'd16);
        reg_write(4'h4, 32'h300);
        b = log_n;
        reg_write(4'h0, 32'h1);
        repeat (6) @(negedge clk);
        reg_write(4'h0, 32'h1);
        reg_write(4'h0, 32'h1);
        wait_idle();
        repeat (5) @(negedge clk);
        check(log_n - b == 12, "R9 no restart while busy", 32'(log_n - b), 32'd12);
        reg_read(4'h0, s);
        check(s == 32'h0, "R9 status", s, 32'h0);
    endtask

    task automatic t_zero();
        logic [31:0] s;
        int b;
        put_desc(32'h340, 32'h111, 32'h20, 32'h40, 32'd0);
        reg_write(4'h4, 32'h340);
        b = log_n;
        reg_write(4'h0, 32'h1);
        wait_idle();
        check_seq(b, 32'h340, 32'h20, 32'h40, 0, 1'b1, 1'b1, "R10 zero count");
        reg_read(4'h0, s);
        check(s == 32'h4 && irq, "R10 flag", s, 32'h4);
        reg_write(4'h0, 32'h4);
    endtask

    task automatic t_odd();
        int b;
        put_desc(32'h380, 32'h110, 32'h20, 32'h70, 32'd6);
        reg_write(4'h4, 32'h380);
        b = log_n;
        reg_write(4'h0, 32'h1);
        wait_idle();
        check_seq(b, 32'h380, 32'h20, 32'h70, 2, 1'b1, 1'b1, "R12 rounded count");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ptr();
        t_copy();
        t_fixed();
        t_busy();
        t_zero();
        t_odd();
        check(hold_err == 0, "R11 request hold", 32'(hold_err), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule